// File: doc/BRIEF.md
# Narrow Target Access Splitter

This block sits between a 32-bit internal bus and a slow external device that is either 8 or 16 bits wide. It takes one internal transfer at a time (an address, a size of byte, half word or word, a direction and 32-bit write data) and turns it into a short run of narrow external beats. Each beat carries its own generated address, the write data moved onto the narrow bus, and a per-byte enable. Beats are passed to a downstream pin-timing sequencer over a valid/ready handshake. For reads, the sequencer returns one narrow data item per beat, and the block places each item into the right byte lanes of a 32-bit holding word. Byte ordering is little-endian throughout.

The control is a four-state machine. IDLE waits for a request and latches it. ISSUE offers the current beat. WAITRD waits for read data after a read beat has been handed off. DONE presents the completion for one cycle. Transitions:
- IDLE→ISSUE on a legal request.
- IDLE→DONE on an illegal request.
- ISSUE→ISSUE on a non-final write hand-off.
- ISSUE→DONE on the final write hand-off.
- ISSUE→WAITRD on any read hand-off.
- WAITRD→ISSUE on a non-final read return.
- WAITRD→DONE on the final read return.
- DONE→IDLE always.

The chip select output is driven from the state. It stays low in ISSUE and WAITRD, so it is held across every beat of a request.

Top module: `narrow_access_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, `beat_valid` is 0, `ext_cs_n` is 1 and `done` is 0.
- R2: The beat count follows the target width code and the size code. Width code `tgt_width` is 00 for an 8-bit target and 01 for a 16-bit target. Size code `req_size` is 00 for byte, 01 for half word and 10 for word. An 8-bit target takes 1, 2 or 4 beats for byte, half word or word. A 16-bit target takes 1, 1 or 2 beats for byte, half word or word.
- R3: On an 8-bit target, beat addresses run upward from the aligned base of the access, with the generated address bits [1:0] selecting the internal byte lane. Write data for that lane appears on `beat_wdata[7:0]`, with `beat_wdata[15:8]` at zero. `beat_lane_en` is 01. On a read, only `rd_data[7:0]` is stored, into the lane given by the beat address bits [1:0].
- R4: On a 16-bit target, address bit 1 picks the internal half word: 0 selects bits [15:0] and 1 selects bits [31:16]. A half-word beat keeps the request's bit 1. A word becomes two beats, with address bit 1 at 0 and then at 1. For these beats, address bit 0 is 0 and `beat_lane_en` is 11.
- R5: A byte access to a 16-bit target is one beat at the request address, carrying the whole selected half word. `beat_lane_en` is 01 when address bit 0 is 0 and 10 when it is 1. On a read, only the enabled byte of `rd_data` is stored.
- R6: `ext_cs_n` is low whenever a beat is offered. It stays low without a gap from one beat's hand-off to the next beat of the same request.
- R7: While `beat_valid` is 1 and `beat_ready` is 0, the beat's address, write data and lane enables hold steady.
- R8: `done` is a single-cycle pulse. It follows the final write hand-off, or the final read return, by one cycle. `done_rdata` holds the assembled word, with zero in every lane not read. For writes, `done_rdata` is zero.
- R9: `req_ready` goes low the cycle after a request is accepted. It stays low until the cycle after `done`.
- R10: A width code of 10 or 11, or a size code of 11, produces no beat. `ext_cs_n` stays 1, and a `done` pulse follows with `done_err` at 1 and `done_rdata` at zero.
- R11: `beat_last` is 1 on the final beat of a request and 0 on the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Internal byte address |
| req_size | input | 2 | 00 byte, 01 half word, 10 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Internal write data |
| tgt_width | input | 2 | 00 8-bit target, 01 16-bit target |
| beat_valid | output | 1 | Narrow beat offered |
| beat_ready | input | 1 | Sequencer takes the beat |
| beat_addr | output | AW | Generated external address |
| beat_write | output | 1 | Beat direction |
| beat_wdata | output | 16 | Narrow write data |
| beat_lane_en | output | 2 | Per-byte enable of the narrow bus |
| beat_last | output | 1 | Final beat of the request |
| ext_cs_n | output | 1 | Active-low chip select held over the beats |
| rd_valid | input | 1 | Read data for the handed-off beat |
| rd_data | input | 16 | Narrow read data |
| done | output | 1 | Completion pulse |
| done_rdata | output | 32 | Assembled read word |
| done_err | output | 1 | Request had an illegal code |

## Verification
A wrong beat counter shows up at the beat ports on the next offered beat. It appears as a wrong generated address, a wrong byte lane or a misplaced `beat_last`, or as a missing or extra beat once `done` fires. A wrong assembly lane appears only at `done_rdata`, one cycle after the final read return. A wrong state shows as a chip select that rises between beats, a `req_ready` that reopens early, or a `done` pulse that is missing or lasts two cycles, all visible within a cycle of the faulty transition.

// File: rtl/nas_pkg.sv
package nas_pkg;
    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;
    localparam logic [1:0] TW_8    = 2'b00;
    localparam logic [1:0] TW_16   = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAITRD,
        ST_DONE
    } nas_state_e;
endpackage

// File: rtl/nas_beat_plan.sv
module nas_beat_plan
    import nas_pkg::*;
(
    input  logic [1:0] width,
    input  logic [1:0] size,
    input  logic [1:0] addr_lo,
    input  logic [1:0] idx,
    output logic [1:0] last_idx,
    output logic [1:0] lo2
);
    always_comb begin
        last_idx = 2'd0;
        lo2      = addr_lo;
        if (width == TW_8) begin
            unique case (size)
                SZ_BYTE: begin last_idx = 2'd0; lo2 = addr_lo; end
                SZ_HALF: begin last_idx = 2'd1; lo2 = {addr_lo[1], idx[0]}; end
                default: begin last_idx = 2'd3; lo2 = idx; end
            endcase
        end else begin
            unique case (size)
                SZ_BYTE: begin last_idx = 2'd0; lo2 = addr_lo; end
                SZ_HALF: begin last_idx = 2'd0; lo2 = {addr_lo[1], 1'b0}; end
                default: begin last_idx = 2'd1; lo2 = {idx[0], 1'b0}; end
            endcase
        end
    end
endmodule

// File: rtl/nas_lane_map.sv
module nas_lane_map
    import nas_pkg::*;
(
    input  logic [1:0]  width,
    input  logic [1:0]  size,
    input  logic [1:0]  lo2,
    input  logic [31:0] wdata,
    input  logic [15:0] rd_data,
    input  logic [31:0] hold_in,
    output logic [15:0] beat_wdata,
    output logic [1:0]  lane_en,
    output logic [31:0] hold_next
);
    always_comb begin
        if (width == TW_8) begin
            beat_wdata = {8'h00, wdata[8*lo2 +: 8]};
            lane_en    = 2'b01;
        end else begin
            beat_wdata = lo2[1] ? wdata[31:16] : wdata[15:0];
            lane_en    = (size == SZ_BYTE) ? (lo2[0] ? 2'b10 : 2'b01) : 2'b11;
        end
        hold_next = hold_in;
        for (int i = 0; i < 4; i++) begin
            if (width == TW_8) begin
                if (lo2 == i[1:0]) hold_next[8*i +: 8] = rd_data[7:0];
            end else if ((lo2[1] == i[1]) && lane_en[i[0]]) begin
                hold_next[8*i +: 8] = i[0] ? rd_data[15:8] : rd_data[7:0];
            end
        end
    end
endmodule

// File: rtl/narrow_access_splitter.sv
module narrow_access_splitter
    import nas_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_write,
    input  logic [31:0]   req_wdata,
    input  logic [1:0]    tgt_width,
    output logic          beat_valid,
    input  logic          beat_ready,
    output logic [AW-1:0] beat_addr,
    output logic          beat_write,
    output logic [15:0]   beat_wdata,
    output logic [1:0]    beat_lane_en,
    output logic          beat_last,
    output logic          ext_cs_n,
    input  logic          rd_valid,
    input  logic [15:0]   rd_data,
    output logic          done,
    output logic [31:0]   done_rdata,
    output logic          done_err
);
    localparam int HI = AW - 1;

    nas_state_e    state, state_d;
    logic [HI:0]   addr_q;
    logic [1:0]    size_q, width_q, idx_q, last_idx, lo2;
    logic          write_q, err_q, in_legal, is_last;
    logic [31:0]   wdata_q, hold_q, hold_next;

    assign in_legal = ((tgt_width == TW_8) || (tgt_width == TW_16)) && (req_size != 2'b11);
    assign is_last  = (idx_q == last_idx);

    nas_beat_plan u_plan (
        .width    (width_q),
        .size     (size_q),
        .addr_lo  (addr_q[1:0]),
        .idx      (idx_q),
        .last_idx (last_idx),
        .lo2      (lo2)
    );

    nas_lane_map u_lane (
        .width      (width_q),
        .size       (size_q),
        .lo2        (lo2),
        .wdata      (wdata_q),
        .rd_data    (rd_data),
        .hold_in    (hold_q),
        .beat_wdata (beat_wdata),
        .lane_en    (beat_lane_en),
        .hold_next  (hold_next)
    );

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_d = in_legal ? ST_ISSUE : ST_DONE;
            ST_ISSUE:  if (beat_ready) begin
                           if (!write_q)     state_d = ST_WAITRD;
                           else if (is_last) state_d = ST_DONE;
                       end
            ST_WAITRD: if (rd_valid) state_d = is_last ? ST_DONE : ST_ISSUE;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            width_q <= TW_8;
            write_q <= 1'b0;
            wdata_q <= '0;
            idx_q   <= '0;
            hold_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state <= state_d;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    addr_q  <= req_addr;
                    size_q  <= req_size;
                    width_q <= tgt_width;
                    write_q <= req_write;
                    wdata_q <= req_wdata;
                    idx_q   <= '0;
                    hold_q  <= '0;
                    err_q   <= !in_legal;
                end
                ST_ISSUE: if (beat_ready && write_q && !is_last) idx_q <= idx_q + 2'd1;
                ST_WAITRD: if (rd_valid) begin
                    hold_q <= hold_next;
                    if (!is_last) idx_q <= idx_q + 2'd1;
                end
                ST_DONE: ;
            endcase
        end
    end

    always_comb begin
        req_ready  = (state == ST_IDLE);
        beat_valid = (state == ST_ISSUE);
        ext_cs_n   = !((state == ST_ISSUE) || (state == ST_WAITRD));
        done       = (state == ST_DONE);
        done_rdata = hold_q;
        done_err   = err_q;
        beat_last  = is_last;
        beat_write = write_q;
        beat_addr  = {addr_q[HI:2], lo2};
    end

    // R6
    cs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !ext_cs_n);
    // R6
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && !beat_last) |=> !ext_cs_n);
    // R7
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr)
            && $stable(beat_wdata) && $stable(beat_lane_en)));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R3
    narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && (width_q == TW_8)) |-> (beat_lane_en == 2'b01));
    // R10
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (!beat_valid && ext_cs_n));
endmodule

// File: tb/sim_narrow_access_splitter.sv
module sim_narrow_access_splitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_size = '0, tgt_width = '0;
    logic        beat_ready = 1'b0, rd_valid = 1'b0;
    logic [15:0] rd_data = '0;
    logic        req_ready, beat_valid, beat_write, beat_last, ext_cs_n, done, done_err;
    logic [31:0] beat_addr, done_rdata;
    logic [15:0] beat_wdata;
    logic [1:0]  beat_lane_en;

    typedef struct {
        logic [31:0] a;
        logic [15:0] wd;
        logic [1:0]  en;
        logic        last;
        logic        wr;
    } exp_beat_t;
    typedef struct {
        logic [31:0] rd;
        logic        err;
    } exp_done_t;

    exp_beat_t eb_q[$];
    exp_done_t ed_q[$];
    int total = 0, bad = 0, cyc = 0;
    logic        pend = 1'b0, gap = 1'b0, stall_seen = 1'b0, finished = 1'b0;
    logic [31:0] paddr = '0, stall_addr = '0;

    always #2 clk = ~clk;

    narrow_access_splitter #(.AW(32)) u0 (.*);

    function automatic logic [15:0] rfn(input logic [31:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] + 8'h11};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] wd, input logic [1:0] w);
        exp_beat_t b;
        exp_done_t d;
        logic [31:0] rexp;
        logic [15:0] r;
        logic [1:0]  lo;
        logic        h, legal;
        int n;
        rexp  = '0;
        legal = ((w == 2'b00) || (w == 2'b01)) && (sz != 2'b11);
        if (legal && w == 2'b00) begin
            n = 1 << sz;
            for (int k = 0; k < n; k++) begin
                lo = (sz == 2'b10) ? k[1:0] : (sz == 2'b01) ? {a[1], k[0]} : a[1:0];
                b.a = {a[31:2], lo}; b.wd = {8'h00, wd[8*lo +: 8]}; b.en = 2'b01;
                b.last = (k == n-1); b.wr = wr; eb_q.push_back(b);
                r = rfn(b.a); rexp[8*lo +: 8] = r[7:0];
            end
        end else if (legal) begin
            n = (sz == 2'b10) ? 2 : 1;
            for (int k = 0; k < n; k++) begin
                if (sz == 2'b00) begin
                    b.a = a; b.en = a[0] ? 2'b10 : 2'b01; h = a[1];
                end else if (sz == 2'b01) begin
                    b.a = {a[31:2], a[1], 1'b0}; b.en = 2'b11; h = a[1];
                end else begin
                    b.a = {a[31:2], k[0], 1'b0}; b.en = 2'b11; h = k[0];
                end
                b.wd = h ? wd[31:16] : wd[15:0]; b.last = (k == n-1); b.wr = wr;
                eb_q.push_back(b);
                r = rfn(b.a);
                if (b.en[0]) rexp[16*h +: 8] = r[7:0];
                if (b.en[1]) rexp[16*h+8 +: 8] = r[15:8];
            end
        end
        d.rd = (wr || !legal) ? 32'h0 : rexp; d.err = !legal;
        ed_q.push_back(d);
        @(posedge clk); #1;
        req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; tgt_width = w; req_valid = 1'b1;
        forever begin @(negedge clk); if (req_ready) break; end
        @(posedge clk); #1; req_valid = 1'b0;
        while (ed_q.size() != 0) begin
            @(negedge clk);
            // R9 no reopening before completion
            if (ed_q.size() != 0 && !done) chk(!req_ready, "R9 ready while busy", {31'd0, req_ready}, 32'd0);
            // R10 illegal stays quiet
            if (!legal) chk(ext_cs_n && !beat_valid, "R10 quiet on illegal", {30'd0, ext_cs_n, beat_valid}, 32'd2);
        end
        // R2 all expected beats issued
        chk(eb_q.size() == 0, "R2 beat count", eb_q.size(), 32'd0);
    endtask

    // sequencer model
    initial forever begin
        @(posedge clk); #1;
        rd_valid = 1'b0;
        if (pend) begin rd_valid = 1'b1; rd_data = rfn(paddr); pend = 1'b0; end
        beat_ready = ((cyc % 3) != 1);
        cyc++;
    end

    // monitor
    initial forever begin
        exp_beat_t e;
        exp_done_t d;
        @(negedge clk);
        if (rst_n) begin
            if (gap) chk(!ext_cs_n, "R6 cs between beats", {31'd0, ext_cs_n}, 32'd0);
            if (beat_valid) begin
                chk(!ext_cs_n, "R6 cs with beat", {31'd0, ext_cs_n}, 32'd0);
                if (stall_seen) chk(beat_addr == stall_addr, "R7 held beat", beat_addr, stall_addr);
                stall_seen = !beat_ready; stall_addr = beat_addr;
            end else stall_seen = 1'b0;
            if (beat_valid && beat_ready) begin
                if (eb_q.size() == 0) chk(1'b0, "R2 extra beat", beat_addr, 32'd0);
                else begin
                    e = eb_q.pop_front();
                    chk(beat_addr == e.a, "R3/R4/R5 beat address", beat_addr, e.a);
                    chk(beat_lane_en == e.en, "R3/R4/R5 lane enable", {30'd0, beat_lane_en}, {30'd0, e.en});
                    chk(beat_last == e.last, "R11 last flag", {31'd0, beat_last}, {31'd0, e.last});
                    if (e.wr) chk(beat_wdata == e.wd, "R3/R4/R5 write data", {16'd0, beat_wdata}, {16'd0, e.wd});
                    if (!e.wr) begin pend = 1'b1; paddr = beat_addr; end
                    gap = !e.last;
                end
            end
            if (done) begin
                if (ed_q.size() == 0) chk(1'b0, "R8 extra done", 32'd1, 32'd0);
                else begin
                    d = ed_q.pop_front();
                    chk(done_rdata == d.rd, "R8 assembled word", done_rdata, d.rd);
                    chk(done_err == d.err, "R10 error flag", {31'd0, done_err}, {31'd0, d.err});
                end
                gap = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !beat_valid && ext_cs_n && !done, "R1 reset state",
            {28'd0, req_ready, beat_valid, ext_cs_n, done}, 32'h0000_000A);
        // 8-bit target
        send(32'h0000_1000, 2'b10, 1'b1, 32'hA1B2_C3D4, 2'b00);
        send(32'h0000_1040, 2'b10, 1'b0, 32'h0, 2'b00);
        send(32'h0000_1022, 2'b01, 1'b0, 32'h0, 2'b00);
        send(32'h0000_1022, 2'b01, 1'b1, 32'h1122_3344, 2'b00);
        send(32'h0000_1013, 2'b00, 1'b0, 32'h0, 2'b00);
        send(32'h0000_1011, 2'b00, 1'b1, 32'h5566_7788, 2'b00);
        // 16-bit target
        send(32'h0000_2000, 2'b10, 1'b1, 32'hDEAD_BEEF, 2'b01);
        send(32'h0000_2084, 2'b10, 1'b0, 32'h0, 2'b01);
        send(32'h0000_2006, 2'b01, 1'b0, 32'h0, 2'b01);
        send(32'h0000_2004, 2'b01, 1'b1, 32'hCAFE_F00D, 2'b01);
        send(32'h0000_2003, 2'b00, 1'b0, 32'h0, 2'b01);
        send(32'h0000_2000, 2'b00, 1'b0, 32'h0, 2'b01);
        send(32'h0000_2001, 2'b00, 1'b1, 32'h0102_0304, 2'b01);
        // illegal codes
        send(32'h0000_3000, 2'b10, 1'b0, 32'h0, 2'b10);
        send(32'h0000_3000, 2'b00, 1'b1, 32'h0, 2'b11);
        send(32'h0000_3000, 2'b11, 1'b0, 32'h0, 2'b01);
        // recovery after illegal
        send(32'h0000_30F0, 2'b10, 1'b0, 32'h0, 2'b00);
        repeat (4) @(posedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule